// File: doc/BRIEF.md
# Flash Internal-Verify Sequencer

This block checks that a range of bytes in one flash block reads the same under normal sensing and under margin sensing. Software programs a small register file with a command code, a block number, a start offset, a block compare value and an end offset. It clears the status register and then raises a one-cycle start pulse, which stands in for the processor entering its halt state. The sequencer walks the range one address per cycle. It compares the two read ports of the flash array at each address and raises a one-cycle done pulse, which lets normal execution resume.

Two verify commands exist. The full-block command scans every offset of the selected block and ignores the offset registers. The ranged command scans from the start offset to the end offset, both inclusive. For both commands the block number and the block compare value must be equal. If they differ, or the start offset is above the end offset, or the command code is unknown, the sequencer records a sequence error and finishes without scanning. A read mismatch records a verify error and stops the walk at that address. Both error flags are sticky.

The controller has four named states. IDLE waits for start. CHECK validates the configuration and loads the walk counter. SCAN compares one address per cycle. FINISH drives done for one cycle. The transitions are named as follows. IDLE→CHECK happens on start. CHECK→SCAN happens when the configuration is valid. CHECK→FINISH happens on a bad configuration (sequence error). SCAN→SCAN steps to the next offset. SCAN→FINISH happens at the last offset or on a mismatch (verify error). FINISH→IDLE always follows.

Top module: `fiv_sequencer`

## Requirements
- R1: After reset every register reads 0, status reads 0 (not busy, no errors) and done_o is low.
- R2: Register offsets: 0 command, 1 block number, 2 start offset, 3 block compare, 4 end offset, 5 status. Writes land on the next clock edge when idle, and rdata_o returns the register selected by addr_i combinationally.
- R3: Command 01h scans offsets 00h through FFh of the block and ignores registers 2 and 4. done_o rises N+1 clock edges after the edge that samples start_i, where N is the number of addresses compared.
- R4: Command 02h scans from the start offset up to the end offset, inclusive, stepping by one offset per cycle.
- R5: A difference between mem_norm_i and mem_marg_i at a scanned address sets status bit 1 and ends the walk at that address.
- R6: When the block number differs from the block compare value, status bit 2 is set and done_o rises one edge after start with no address compared.
- R7: Under command 02h, a start offset greater than the end offset sets status bit 2 and ends without scanning.
- R8: Any command code other than 01h or 02h sets status bit 2 and ends without scanning.
- R9: Status bits 1 and 2 stay set across later runs until software writes the status register while idle. Such a write clears both bits.
- R10: Status bit 0 reads 1 from the cycle after start until done. Register writes and start pulses arriving in that time are ignored.
- R11: done_o is high for exactly one cycle per run.
- R12: While scanning, mem_addr_o carries {block number, current offset}, and the first address driven is the first offset of the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register select for read and write |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Selected register contents |
| start_i | input | 1 | One-cycle start pulse (halt event) |
| done_o | output | 1 | One-cycle completion pulse |
| mem_addr_o | output | 16 | Flash address {block, offset} |
| mem_rd_o | output | 1 | Flash read strobe, high while scanning |
| mem_norm_i | input | 8 | Normal-sense read data at mem_addr_o |
| mem_marg_i | input | 8 | Margin-sense read data at mem_addr_o |

## Verification
A wrong state or a stuck walk counter shows at the ports as a done pulse that arrives too early or too late. The bench times every run from the start edge, so an off-by-one in the range or a skipped CHECK state is caught on the very run that triggers it. A fault planted at a chosen offset shows whether the counter is at the right address, because the verify error must appear only when the fault lies inside the range. In that case the run length shows the address where the walk stopped. Lost sticky flags or a register that was not locked show up on the first status or register read after the run.

// File: rtl/fiv_pkg.sv
package fiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_SCAN   = 2'd2,
        ST_FINISH = 2'd3
    } fiv_state_e;

    localparam logic [7:0] CMD_FULL  = 8'h01;
    localparam logic [7:0] CMD_RANGE = 8'h02;

    localparam logic [2:0] RA_CMD     = 3'd0;
    localparam logic [2:0] RA_BLK     = 3'd1;
    localparam logic [2:0] RA_OFS     = 3'd2;
    localparam logic [2:0] RA_BLK_CMP = 3'd3;
    localparam logic [2:0] RA_OFS_END = 3'd4;
    localparam logic [2:0] RA_STAT    = 3'd5;
endpackage

// File: rtl/fiv_regs.sv
module fiv_regs
    import fiv_pkg::*;
#(
    parameter int BLK_W = 8,
    parameter int OFF_W = 8,
    parameter int REG_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_en_i,
    input  logic [2:0]       addr_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic             busy_i,
    input  logic             set_verr_i,
    input  logic             set_seqerr_i,
    output logic [REG_W-1:0] rdata_o,
    output logic [7:0]       cmd_o,
    output logic [BLK_W-1:0] blk_o,
    output logic [OFF_W-1:0] ofs_o,
    output logic [BLK_W-1:0] blk_cmp_o,
    output logic [OFF_W-1:0] ofs_end_o
);
    logic             wr_ok;
    logic             verr_q;
    logic             seqerr_q;
    logic [7:0]       cmd_q;
    logic [BLK_W-1:0] blk_q;
    logic [BLK_W-1:0] blk_cmp_q;
    logic [OFF_W-1:0] ofs_q;
    logic [OFF_W-1:0] ofs_end_q;

    assign wr_ok = wr_en_i && !busy_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cmd_q     <= '0;
            blk_q     <= '0;
            blk_cmp_q <= '0;
            ofs_q     <= '0;
            ofs_end_q <= '0;
            verr_q    <= 1'b0;
            seqerr_q  <= 1'b0;
        end else begin
            if (wr_ok) begin
                case (addr_i)
                    RA_CMD:     cmd_q     <= wdata_i[7:0];
                    RA_BLK:     blk_q     <= wdata_i[BLK_W-1:0];
                    RA_OFS:     ofs_q     <= wdata_i[OFF_W-1:0];
                    RA_BLK_CMP: blk_cmp_q <= wdata_i[BLK_W-1:0];
                    RA_OFS_END: ofs_end_q <= wdata_i[OFF_W-1:0];
                    RA_STAT: begin
                        verr_q   <= 1'b0;
                        seqerr_q <= 1'b0;
                    end
                    default: ;
                endcase
            end
            if (set_verr_i)   verr_q   <= 1'b1;
            if (set_seqerr_i) seqerr_q <= 1'b1;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            RA_CMD:     rdata_o = REG_W'(cmd_q);
            RA_BLK:     rdata_o = REG_W'(blk_q);
            RA_OFS:     rdata_o = REG_W'(ofs_q);
            RA_BLK_CMP: rdata_o = REG_W'(blk_cmp_q);
            RA_OFS_END: rdata_o = REG_W'(ofs_end_q);
            RA_STAT:    rdata_o = REG_W'({seqerr_q, verr_q, busy_i});
            default:    rdata_o = '0;
        endcase
    end

    assign cmd_o     = cmd_q;
    assign blk_o     = blk_q;
    assign ofs_o     = ofs_q;
    assign blk_cmp_o = blk_cmp_q;
    assign ofs_end_o = ofs_end_q;

    AST_LOCKED_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_i && wr_en_i) |=> ($stable(blk_q) && $stable(ofs_q) && $stable(cmd_q))); // R10
    AST_STICKY_VERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (verr_q && !(wr_ok && addr_i == RA_STAT)) |=> verr_q); // R9
    AST_STICKY_SEQERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seqerr_q && !(wr_ok && addr_i == RA_STAT)) |=> seqerr_q); // R9
endmodule

// File: rtl/fiv_range_sel.sv
module fiv_range_sel
    import fiv_pkg::*;
#(
    parameter int BLK_W = 8,
    parameter int OFF_W = 8
) (
    input  logic [7:0]       cmd_i,
    input  logic [BLK_W-1:0] blk_i,
    input  logic [BLK_W-1:0] blk_cmp_i,
    input  logic [OFF_W-1:0] ofs_i,
    input  logic [OFF_W-1:0] ofs_end_i,
    output logic             cfg_ok_o,
    output logic [OFF_W-1:0] first_o,
    output logic [OFF_W-1:0] last_o
);
    logic blk_match;

    assign blk_match = (blk_i == blk_cmp_i);

    always_comb begin
        first_o  = ofs_i;
        last_o   = ofs_end_i;
        cfg_ok_o = 1'b0;
        case (cmd_i)
            CMD_FULL: begin
                first_o  = '0;
                last_o   = '1;
                cfg_ok_o = blk_match;
            end
            CMD_RANGE: begin
                cfg_ok_o = blk_match && (ofs_i <= ofs_end_i);
            end
            default: cfg_ok_o = 1'b0;
        endcase
    end

    AST_OK_ORDERED: assert final (!cfg_ok_o || (first_o <= last_o)); // R7
endmodule

// File: rtl/fiv_ctrl.sv
module fiv_ctrl
    import fiv_pkg::*;
#(
    parameter int BLK_W  = 8,
    parameter int OFF_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              cfg_ok_i,
    input  logic [OFF_W-1:0]  first_i,
    input  logic [OFF_W-1:0]  last_i,
    input  logic [BLK_W-1:0]  blk_i,
    input  logic [DATA_W-1:0] mem_norm_i,
    input  logic [DATA_W-1:0] mem_marg_i,
    output logic [BLK_W+OFF_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              set_verr_o,
    output logic              set_seqerr_o
);
    fiv_state_e       state_q, state_d;
    logic [OFF_W-1:0] cur_q;
    logic [OFF_W-1:0] last_q;
    logic [BLK_W-1:0] blk_q;
    logic             mismatch;
    logic             at_last;

    assign mismatch = (mem_norm_i != mem_marg_i);
    assign at_last  = (cur_q == last_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_CHECK;
            ST_CHECK:  state_d = cfg_ok_i ? ST_SCAN : ST_FINISH;
            ST_SCAN:   if (mismatch || at_last) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q  <= '0;
            last_q <= '0;
            blk_q  <= '0;
        end else begin
            if (state_q == ST_CHECK) begin
                cur_q  <= first_i;
                last_q <= last_i;
                blk_q  <= blk_i;
            end else if (state_q == ST_SCAN && !mismatch && !at_last) begin
                cur_q <= cur_q + OFF_W'(1);
            end
        end
    end

    always_comb begin
        mem_rd_o     = 1'b0;
        busy_o       = 1'b1;
        done_o       = 1'b0;
        set_verr_o   = 1'b0;
        set_seqerr_o = 1'b0;
        unique case (state_q)
            ST_IDLE:   busy_o = 1'b0;
            ST_CHECK:  set_seqerr_o = !cfg_ok_i;
            ST_SCAN: begin
                mem_rd_o   = 1'b1;
                set_verr_o = mismatch;
            end
            ST_FINISH: done_o = 1'b1;
        endcase
    end

    assign mem_addr_o = {blk_q, cur_q};

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R11
    AST_BAD_CFG_NO_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_CHECK && !cfg_ok_i) |=> (state_q == ST_FINISH)); // R6
    AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SCAN && $past(state_q) == ST_SCAN) |-> (cur_q == $past(cur_q) + OFF_W'(1))); // R4
    AST_ADDR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SCAN) |-> (cur_q <= last_q)); // R4
    AST_STOP_ON_MISMATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SCAN && mismatch) |=> (state_q == ST_FINISH)); // R5
endmodule

// File: rtl/fiv_sequencer.sv
module fiv_sequencer
    import fiv_pkg::*;
#(
    parameter int BLK_W  = 8,
    parameter int OFF_W  = 8,
    parameter int DATA_W = 8,
    parameter int REG_W  = 8,
    localparam int ADDR_W = BLK_W + OFF_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [2:0]        addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    output logic [REG_W-1:0]  rdata_o,
    input  logic              start_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_o,
    input  logic [DATA_W-1:0] mem_norm_i,
    input  logic [DATA_W-1:0] mem_marg_i
);
    logic             busy;
    logic             set_verr;
    logic             set_seqerr;
    logic             cfg_ok;
    logic [7:0]       cmd;
    logic [BLK_W-1:0] blk;
    logic [BLK_W-1:0] blk_cmp;
    logic [OFF_W-1:0] ofs;
    logic [OFF_W-1:0] ofs_end;
    logic [OFF_W-1:0] first;
    logic [OFF_W-1:0] last;

    fiv_regs #(.BLK_W(BLK_W), .OFF_W(OFF_W), .REG_W(REG_W)) regs_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_en_i      (wr_en_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .busy_i       (busy),
        .set_verr_i   (set_verr),
        .set_seqerr_i (set_seqerr),
        .rdata_o      (rdata_o),
        .cmd_o        (cmd),
        .blk_o        (blk),
        .ofs_o        (ofs),
        .blk_cmp_o    (blk_cmp),
        .ofs_end_o    (ofs_end)
    );

    fiv_range_sel #(.BLK_W(BLK_W), .OFF_W(OFF_W)) sel_i (
        .cmd_i     (cmd),
        .blk_i     (blk),
        .blk_cmp_i (blk_cmp),
        .ofs_i     (ofs),
        .ofs_end_i (ofs_end),
        .cfg_ok_o  (cfg_ok),
        .first_o   (first),
        .last_o    (last)
    );

    fiv_ctrl #(.BLK_W(BLK_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) ctrl_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start_i),
        .cfg_ok_i     (cfg_ok),
        .first_i      (first),
        .last_i       (last),
        .blk_i        (blk),
        .mem_norm_i   (mem_norm_i),
        .mem_marg_i   (mem_marg_i),
        .mem_addr_o   (mem_addr_o),
        .mem_rd_o     (mem_rd_o),
        .busy_o       (busy),
        .done_o       (done_o),
        .set_verr_o   (set_verr),
        .set_seqerr_o (set_seqerr)
    );

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !busy); // R10
endmodule

// File: tb/fiv_sequencer_tb_top.sv
module fiv_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [7:0]  wdata = 8'd0;
    logic [7:0]  rdata;
    logic        start = 1'b0;
    logic        done;
    logic [15:0] mem_addr;
    logic        mem_rd;
    logic [7:0]  norm;
    logic [7:0]  marg;
    logic        fault_en = 1'b0;
    logic [15:0] fault_addr = 16'd0;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    fiv_sequencer dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .start_i(start), .done_o(done),
        .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_norm_i(norm), .mem_marg_i(marg)
    );

    always_comb begin
        norm = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'h5A;
        marg = (fault_en && mem_addr == fault_addr) ? (norm ^ 8'h01) : norm;
    end

    typedef struct packed {
        logic [7:0]  cmd;
        logic [7:0]  blk;
        logic [7:0]  ofs;
        logic [7:0]  bcmp;
        logic [7:0]  oend;
        logic        fen;
        logic [15:0] faddr;
        logic [1:0]  err;   // {seq, verify}
        logic [15:0] cnt;   // edges from start edge to done
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{8'h01, 8'h03, 8'h40, 8'h03, 8'h10, 1'b0, 16'h0000, 2'b00, 16'd257, 8'd3},  // R3 full, offsets ignored
        '{8'h01, 8'h03, 8'h00, 8'h03, 8'hFF, 1'b1, 16'h0380, 2'b01, 16'd130, 8'd5},  // R5 stop mid block
        '{8'h02, 8'h05, 8'h10, 8'h05, 8'h1F, 1'b0, 16'h0000, 2'b00, 16'd17,  8'd4},  // R4 range
        '{8'h02, 8'h05, 8'h33, 8'h05, 8'h33, 1'b0, 16'h0000, 2'b00, 16'd2,   8'd4},  // R4 single
        '{8'h02, 8'h05, 8'h10, 8'h05, 8'h1F, 1'b1, 16'h051F, 2'b01, 16'd17,  8'd5},  // R5 at last
        '{8'h02, 8'h05, 8'h10, 8'h05, 8'h1F, 1'b1, 16'h0510, 2'b01, 16'd2,   8'd5},  // R5 at first
        '{8'h02, 8'h05, 8'h10, 8'h05, 8'h1F, 1'b1, 16'h0520, 2'b00, 16'd17,  8'd4},  // R4 fault outside
        '{8'h02, 8'h05, 8'h20, 8'h05, 8'h1F, 1'b0, 16'h0000, 2'b10, 16'd1,   8'd7},  // R7
        '{8'h02, 8'h05, 8'h10, 8'h06, 8'h1F, 1'b0, 16'h0000, 2'b10, 16'd1,   8'd6},  // R6
        '{8'h01, 8'h02, 8'h00, 8'h09, 8'hFF, 1'b0, 16'h0000, 2'b10, 16'd1,   8'd6},  // R6 full
        '{8'h03, 8'h05, 8'h10, 8'h05, 8'h1F, 1'b0, 16'h0000, 2'b10, 16'd1,   8'd8},  // R8
        '{8'h00, 8'h05, 8'h10, 8'h05, 8'h1F, 1'b0, 16'h0000, 2'b10, 16'd1,   8'd8}   // R8
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    // Pulse start and count edges until done; returns first scanned address
    task automatic run(output int cnt, output logic [15:0] first_addr);
        @(negedge clk);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        first_addr = 16'hXXXX;
        while (cnt < 1000) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (cnt == 1) first_addr = mem_addr;
            if (done) break;
        end
        @(negedge clk);
        chk("R11 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] fa;
        int          cnt;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 reset register", int'(d), 0);
        end
        chk("R1 done low", int'(done), 0);

        // R2 register readback
        wr(3'd1, 8'hA5); wr(3'd2, 8'h3C); wr(3'd3, 8'h5A); wr(3'd4, 8'hC3); wr(3'd0, 8'h02);
        rd(3'd1, d); chk("R2 block", int'(d), 8'hA5);
        rd(3'd2, d); chk("R2 start offset", int'(d), 8'h3C);
        rd(3'd3, d); chk("R2 block compare", int'(d), 8'h5A);
        rd(3'd4, d); chk("R2 end offset", int'(d), 8'hC3);
        rd(3'd0, d); chk("R2 command", int'(d), 8'h02);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            wr(3'd5, 8'h00);
            wr(3'd0, VECS[i].cmd); wr(3'd1, VECS[i].blk); wr(3'd2, VECS[i].ofs);
            wr(3'd3, VECS[i].bcmp); wr(3'd4, VECS[i].oend);
            fault_en = VECS[i].fen; fault_addr = VECS[i].faddr;
            run(cnt, fa);
            $display("vector %0d covers R%0d", i, VECS[i].req);
            chk("R3/R4/R6 run length", cnt, int'(VECS[i].cnt));
            rd(3'd5, d);
            chk("R5/R6/R7/R8 status errors", int'(d[2:1]), int'(VECS[i].err));
            chk("R10 idle after done", int'(d[0]), 0);
            if (VECS[i].err[1] == 1'b0)
                chk("R12 first address", int'(fa),
                    int'({VECS[i].blk, (VECS[i].cmd == 8'h01) ? 8'h00 : VECS[i].ofs}));
        end
        fault_en = 1'b0;

        // R9 sticky: set verify error, then a clean run without clearing
        wr(3'd5, 8'h00);
        wr(3'd0, 8'h02); wr(3'd1, 8'h07); wr(3'd2, 8'h00); wr(3'd3, 8'h07); wr(3'd4, 8'h04);
        fault_en = 1'b1; fault_addr = 16'h0702;
        run(cnt, fa);
        fault_en = 1'b0;
        run(cnt, fa);
        chk("R9 clean run length", cnt, 6);
        rd(3'd5, d); chk("R9 verify error sticky", int'(d[2:1]), 1);
        wr(3'd0, 8'h09);
        run(cnt, fa);
        rd(3'd5, d); chk("R9 both errors sticky", int'(d[2:1]), 3);
        wr(3'd5, 8'hFF);
        rd(3'd5, d); chk("R9 status write clears", int'(d), 0);

        // R10 busy flag, locked registers, second start ignored
        wr(3'd0, 8'h01); wr(3'd1, 8'h04); wr(3'd3, 8'h04);
        @(negedge clk); start = 1'b1;
        @(posedge clk);
        @(negedge clk); start = 1'b0;
        cnt = 0;
        repeat (3) begin @(posedge clk); cnt++; @(negedge clk); end
        rd(3'd5, d); chk("R10 busy during run", int'(d[0]), 1);
        wr_en = 1'b1; addr = 3'd1; wdata = 8'h77;
        @(posedge clk); cnt++; @(negedge clk);
        wr_en = 1'b0; start = 1'b1;
        @(posedge clk); cnt++; @(negedge clk);
        start = 1'b0;
        while (cnt < 1000 && !done) begin @(posedge clk); cnt++; @(negedge clk); end
        chk("R10 second start ignored", cnt, 257);
        @(negedge clk);
        rd(3'd1, d); chk("R10 write while busy ignored", int'(d), 8'h04);
        rd(3'd5, d); chk("R10 status after run", int'(d), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule